// File: doc/BRIEF.md
# Remapped 8-Bit Pin Bank

This block sits between a test sequencer and a 40-position chip socket. It keeps a table of up to sixteen virtual byte-wide ports ("banks"). Each bank assigns every one of its eight bits to a chip pin of the test's choosing. A bank can be written with a value, which drives or releases a chosen number of its low bits. It can also be read, which senses the socket pins behind the bank and returns a byte tagged with a destination register number.

Chip pin numbers are turned into socket positions from the chip's pin count. The model is a dual-in-line part that sits against the bottom of a 40-pin socket. A chip of N pins therefore has its pin k at socket pin k + 20 - N/2. Socket pin p (1 to 40) is bit p-1 of the direction, level and sense vectors. A direction bit of 1 means the tester drives that socket pin.

Commands arrive one at a time, qualified by `cmd_valid` and accepted when `cmd_ready` is high. A read moves a four-state controller through IDLE, SYNC1, SYNC2 and CAPT. The transitions are: IDLE to SYNC1 on an accepted read; SYNC1 to SYNC2 and SYNC2 to CAPT unconditionally; and CAPT to IDLE, which raises the result. Define, drive and no-op commands leave the controller in IDLE.

Top module: `pinbank_bank`

## Requirements
- R1: After reset every socket direction and level bit is 0, `rd_valid` is 0 and `cmd_ready` is 1.
- R2: An accepted define (`cmd_op` = 0) stores `{cmd_pins_hi, cmd_pins_lo}` into bank `cmd_bank` and leaves `sock_dir` and `sock_lvl` unchanged.
- R3: In a stored bank, byte j (bits 8j+7..8j) of `cmd_pins_lo` is the chip pin of bank bit j, and byte j of `cmd_pins_hi` is the chip pin of bank bit 4+j, for j = 0..3.
- R4: Chip pin k of an N-pin chip (`chip_pins` = N) maps to socket vector bit k + 19 - N/2. A bank bit is unmapped when k is 0, when k exceeds N, or when N is 0, odd or above 40. Unmapped bits never touch the socket and read as 0.
- R5: An accepted drive (`cmd_op` = 1) changes only bank bits below the bit count, where `cmd_count` values above 8 act as 8. For each such mapped bit, the direction becomes `cmd_drive` and the level becomes bit i of `cmd_value`. All other socket bits keep their direction and level.
- R6: When several bits of one bank name the same socket pin, the highest-numbered of those bits decides that pin on a drive.
- R7: An accepted read (`cmd_op` = 2) turns every mapped pin of the bank into an input from the next cycle on, whatever the bit count. Levels are left unchanged.
- R8: A read samples `sock_in` through a two-flop synchronizer. `rd_valid` is high for exactly one cycle, the fourth cycle after the accept cycle. At that point `rd_dest` equals the read's `cmd_dest`, and bit i of `rd_data` is the sensed socket pin of bank bit i for i below the clamped count and 0 otherwise.
- R9: `cmd_ready` is low from the cycle after a read is accepted until `rd_valid` rises. Commands offered while it is low are dropped and have no effect.
- R10: An accepted command with `cmd_op` = 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| chip_pins | input | 8 | Pin count N of the chip in the socket |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Controller idle, command will be taken |
| cmd_op | input | 2 | 0 define, 1 drive, 2 read, 3 no-op |
| cmd_bank | input | 4 | Bank index |
| cmd_pins_lo | input | 32 | Packed chip pins for bank bits 0..3 |
| cmd_pins_hi | input | 32 | Packed chip pins for bank bits 4..7 |
| cmd_count | input | 4 | Number of low bank bits affected |
| cmd_value | input | 8 | Value for a drive |
| cmd_drive | input | 1 | 1 = tester drives the pins, 0 = input |
| cmd_dest | input | 5 | Destination register tag for a read |
| sock_in | input | 40 | Sensed socket pin levels (asynchronous) |
| sock_dir | output | 40 | Socket direction, 1 = driven |
| sock_lvl | output | 40 | Socket drive level |
| rd_valid | output | 1 | Read result present |
| rd_data | output | 8 | Read result, bank bit 0 in the LSB |
| rd_dest | output | 5 | Register tag of the read result |

## Verification
Two things can be asked of one socket pin in the same cycle. One case is a second command offered while a read is still in SYNC1 to CAPT. The bench holds a drive on the command port through that window and judges, from the direction and level outputs and the returned byte, that only the read took effect. The other case is a drive whose bank lists the same pin under several bits. The bench expects the highest such bit to set the pin, and it checks the socket vectors in the cycle after acceptance.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    localparam int BITS = 8;
    localparam int MAPW = BITS * 8;

    typedef enum logic [1:0] {
        OP_DEFINE = 2'd0,
        OP_DRIVE  = 2'd1,
        OP_READ   = 2'd2,
        OP_NOP    = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SYNC1 = 2'd1,
        S_SYNC2 = 2'd2,
        S_CAPT  = 2'd3
    } state_e;

    function automatic logic [3:0] clamp_count(input logic [3:0] c);
        return (c > 4'(BITS)) ? 4'(BITS) : c;
    endfunction

endpackage

// File: rtl/pinbank_table.sv
module pinbank_table #(
    parameter int BANKS = 16,
    parameter int MAPW  = 64,
    localparam int BW   = $clog2(BANKS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [BW-1:0]   waddr,
    input  logic [MAPW-1:0] wdata,
    input  logic [BW-1:0]   raddr,
    output logic [MAPW-1:0] rdata
);
    logic [MAPW-1:0] mem [BANKS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < BANKS; b++) mem[b] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int W = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/pinbank_remap.sv
module pinbank_remap #(
    parameter int BITS = 8,
    parameter int SOCK = 40,
    localparam int IW  = $clog2(SOCK)
) (
    input  logic [BITS*8-1:0]        map,
    input  logic [7:0]               n_pins,
    output logic [BITS-1:0][IW-1:0]  idx,
    output logic [BITS-1:0]          ok
);
    logic n_good;
    assign n_good = (n_pins != 8'd0) && (n_pins <= 8'(SOCK)) && !n_pins[0];

    for (genvar g = 0; g < BITS; g++) begin : g_bit
        logic [7:0] pin;
        assign pin = map[g*8 +: 8];
        always_comb begin
            ok[g]  = n_good && (pin != 8'd0) && (pin <= n_pins);
            idx[g] = ok[g] ? (IW'(pin) + IW'(SOCK/2) - IW'(n_pins >> 1) - IW'(1)) : '0;
        end
    end
endmodule

// File: rtl/pinbank_bank.sv
module pinbank_bank
    import pinbank_pkg::*;
#(
    parameter int BANKS = 16,
    parameter int SOCK  = 40,
    parameter int REGW  = 5,
    localparam int BW   = $clog2(BANKS),
    localparam int IW   = $clog2(SOCK)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [7:0]      chip_pins,
    input  logic            cmd_valid,
    output logic            cmd_ready,
    input  logic [1:0]      cmd_op,
    input  logic [BW-1:0]   cmd_bank,
    input  logic [31:0]     cmd_pins_lo,
    input  logic [31:0]     cmd_pins_hi,
    input  logic [3:0]      cmd_count,
    input  logic [7:0]      cmd_value,
    input  logic            cmd_drive,
    input  logic [REGW-1:0] cmd_dest,
    input  logic [SOCK-1:0] sock_in,
    output logic [SOCK-1:0] sock_dir,
    output logic [SOCK-1:0] sock_lvl,
    output logic            rd_valid,
    output logic [7:0]      rd_data,
    output logic [REGW-1:0] rd_dest
);
    state_e                 state, state_nxt;
    op_e                    op;
    logic                   accept;
    logic [BW-1:0]          bank_q, bank_sel;
    logic [3:0]             cnt, rd_cnt_q;
    logic [REGW-1:0]        dest_q;
    logic [MAPW-1:0]        entry;
    logic [BITS-1:0][IW-1:0] idx;
    logic [BITS-1:0]        ok;
    logic [SOCK-1:0]        sync_q;

    assign op        = op_e'(cmd_op);
    assign cmd_ready = (state == S_IDLE);
    assign accept    = cmd_valid && cmd_ready;
    assign bank_sel  = (state == S_IDLE) ? cmd_bank : bank_q;
    assign cnt       = clamp_count(cmd_count);

    pinbank_table #(.BANKS(BANKS), .MAPW(MAPW)) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (accept && (op == OP_DEFINE)),
        .waddr (cmd_bank),
        .wdata ({cmd_pins_hi, cmd_pins_lo}),
        .raddr (bank_sel),
        .rdata (entry)
    );

    pinbank_remap #(.BITS(BITS), .SOCK(SOCK)) u_remap (
        .map    (entry),
        .n_pins (chip_pins),
        .idx    (idx),
        .ok     (ok)
    );

    pinbank_sync #(.W(SOCK)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (sock_in),
        .q     (sync_q)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE:  if (cmd_valid && op == OP_READ) state_nxt = S_SYNC1;
            S_SYNC1: state_nxt = S_SYNC2;
            S_SYNC2: state_nxt = S_CAPT;
            S_CAPT:  state_nxt = S_IDLE;
        endcase
    end

    // Outputs and per-command effects
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sock_dir <= '0;
            sock_lvl <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
            rd_dest  <= '0;
            bank_q   <= '0;
            rd_cnt_q <= '0;
            dest_q   <= '0;
        end else begin
            rd_valid <= 1'b0;
            if (accept) begin
                unique case (op)
                    OP_DRIVE: begin
                        for (int i = 0; i < BITS; i++) begin
                            if ((4'(i) < cnt) && ok[i]) begin
                                sock_dir[idx[i]] <= cmd_drive;
                                sock_lvl[idx[i]] <= cmd_value[i];
                            end
                        end
                    end
                    OP_READ: begin
                        for (int i = 0; i < BITS; i++) begin
                            if (ok[i]) sock_dir[idx[i]] <= 1'b0;
                        end
                        bank_q   <= cmd_bank;
                        rd_cnt_q <= cnt;
                        dest_q   <= cmd_dest;
                    end
                    default: ;
                endcase
            end
            if (state == S_CAPT) begin
                rd_valid <= 1'b1;
                rd_dest  <= dest_q;
                for (int i = 0; i < BITS; i++) begin
                    rd_data[i] <= ((4'(i) < rd_cnt_q) && ok[i]) ? sync_q[idx[i]] : 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/pinbank_chk.sv
module pinbank_chk #(
    parameter int SOCK = 40
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic            cmd_ready,
    input logic [1:0]      cmd_op,
    input logic [SOCK-1:0] sock_dir,
    input logic [SOCK-1:0] sock_lvl,
    input logic            rd_valid,
    input logic [7:0]      rd_data,
    input logic [3:0]      rd_cnt_q
);
    p_define_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == 2'd0) |=> ($stable(sock_dir) && $stable(sock_lvl)));

    p_read_only_releases_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == 2'd2) |=> ($stable(sock_lvl) && ((sock_dir & ~$past(sock_dir)) == '0)));

    p_result_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    p_high_bits_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ((rd_data >> rd_cnt_q) == 8'd0));

    p_busy_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == 2'd2) |=> !cmd_ready);

    p_busy_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ready |=> ($stable(sock_dir) && $stable(sock_lvl)));

    p_ready_with_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> cmd_ready);

    p_nop_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == 2'd3) |=> ($stable(sock_dir) && $stable(sock_lvl)));
endmodule

bind pinbank_bank pinbank_chk #(.SOCK(SOCK)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .sock_dir  (sock_dir),
    .sock_lvl  (sock_lvl),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .rd_cnt_q  (rd_cnt_q)
);

// File: tb/sim_pinbank_bank.sv
`timescale 1ns/1ps
module sim_pinbank_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  chip_pins = 8'd16;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = '0;
    logic [3:0]  cmd_bank = '0;
    logic [31:0] cmd_pins_lo = '0, cmd_pins_hi = '0;
    logic [3:0]  cmd_count = '0;
    logic [7:0]  cmd_value = '0;
    logic        cmd_drive = 1'b0;
    logic [4:0]  cmd_dest = '0;
    logic [39:0] sock_in = '0;
    logic [39:0] sock_dir, sock_lvl;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [4:0]  rd_dest;

    int total = 0, failed = 0;
    bit done = 0;
    logic [63:0] mbank [16];
    logic [39:0] mdir = '0, mlvl = '0;

    always #4 clk = ~clk;

    pinbank_bank u0 (.*);

    task automatic chk(input bit good, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!good) begin
            failed++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int spos(logic [7:0] k, int n);
        if (n == 0 || n > 40 || (n % 2) != 0) return -1;
        if (k == 0 || k > n) return -1;
        return k + 19 - n / 2;
    endfunction

    task automatic check_sock(input string req);
        chk(sock_dir === mdir, req, {24'd0, sock_dir}, {24'd0, mdir});
        chk(sock_lvl === mlvl, req, {24'd0, sock_lvl}, {24'd0, mlvl});
    endtask

    task automatic issue(input logic [1:0] op, input logic [3:0] b, input logic [31:0] lo, input logic [31:0] hi,
                         input logic [3:0] c, input logic [7:0] v, input logic d, input logic [4:0] dst);
        cmd_op = op; cmd_bank = b; cmd_pins_lo = lo; cmd_pins_hi = hi;
        cmd_count = c; cmd_value = v; cmd_drive = d; cmd_dest = dst; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic do_define(input logic [3:0] b, input logic [31:0] lo, input logic [31:0] hi);
        mbank[b] = {hi, lo};
        issue(2'd0, b, lo, hi, 4'd0, 8'd0, 1'b0, 5'd0);
        check_sock("R2");
    endtask

    task automatic do_drive(input logic [3:0] b, input logic [3:0] c, input logic [7:0] v, input logic d, input string req);
        int ec = (c > 8) ? 8 : int'(c);
        for (int i = 0; i < ec; i++) begin
            int p = spos(mbank[b][i*8 +: 8], int'(chip_pins));
            if (p >= 0) begin mdir[p] = d; mlvl[p] = v[i]; end
        end
        issue(2'd1, b, 32'd0, 32'd0, c, v, d, 5'd0);
        check_sock(req);
    endtask

    task automatic do_read(input logic [3:0] b, input logic [3:0] c, input logic [4:0] dst, input logic [39:0] pins,
                           input bit busy_poke, input string req);
        int ec = (c > 8) ? 8 : int'(c);
        logic [7:0] exp = '0;
        int waited = 0;
        sock_in = pins;
        for (int i = 0; i < 8; i++) begin
            int p = spos(mbank[b][i*8 +: 8], int'(chip_pins));
            if (p >= 0) begin
                mdir[p] = 1'b0;
                if (i < ec) exp[i] = pins[p];
            end
        end
        issue(2'd2, b, 32'd0, 32'd0, c, 8'd0, 1'b0, dst);
        check_sock("R7");
        chk(cmd_ready == 1'b0, "R9", {63'd0, cmd_ready}, 64'd0);
        if (busy_poke) begin
            cmd_op = 2'd1; cmd_bank = b; cmd_count = 4'd8; cmd_value = 8'hFF; cmd_drive = 1'b1; cmd_valid = 1'b1;
        end
        while (!rd_valid && waited < 10) begin
            @(negedge clk);
            waited++;
            if (waited == 2) cmd_valid = 1'b0;
        end
        cmd_valid = 1'b0;
        chk(waited == 3, "R8", 64'(waited), 64'd3);
        chk(rd_data === exp, req, {56'd0, rd_data}, {56'd0, exp});
        chk(rd_dest === dst, "R8", {59'd0, rd_dest}, {59'd0, dst});
        if (busy_poke) check_sock("R9");
        @(negedge clk);
        chk(rd_valid == 1'b0, "R8", {63'd0, rd_valid}, 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failed++; total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int b = 0; b < 16; b++) mbank[b] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(sock_dir == 40'd0 && sock_lvl == 40'd0, "R1", {24'd0, sock_dir | sock_lvl}, 64'd0);
        chk(rd_valid == 1'b0 && cmd_ready == 1'b1, "R1", {62'd0, rd_valid, cmd_ready}, 64'd1);

        // R3 R4 R5: 16-pin chip, pins 1..8 land on socket pins 13..20
        chip_pins = 8'd16;
        do_define(4'd0, 32'h04030201, 32'h08070605);
        do_drive(4'd0, 4'd8, 8'hA5, 1'b1, "R3");
        chk(sock_dir == 40'h00000FF000, "R4", {24'd0, sock_dir}, 64'h0FF000);
        chk(sock_lvl == 40'h00000A5000, "R3", {24'd0, sock_lvl}, 64'h0A5000);
        // R5 partial count then clamp
        do_define(4'd1, 32'h0C0B0A09, 32'h100F0E0D);
        do_drive(4'd1, 4'd3, 8'hFF, 1'b1, "R5");
        chk(sock_dir == 40'h00007FF000, "R5", {24'd0, sock_dir}, 64'h7FF000);
        do_drive(4'd1, 4'd15, 8'h0F, 1'b1, "R5");
        // R4 unmapped: pin 0, pin above N, odd N
        do_define(4'd2, 32'h00110000, 32'h00000001);
        do_drive(4'd2, 4'd8, 8'h00, 1'b0, "R4");
        chk(sock_dir[12] == 1'b0, "R4", {63'd0, sock_dir[12]}, 64'd0);
        chip_pins = 8'd15;
        do_drive(4'd0, 4'd8, 8'h00, 1'b0, "R4");
        chip_pins = 8'd40;
        do_drive(4'd0, 4'd8, 8'h3C, 1'b1, "R4");
        chk(sock_dir[7:0] == 8'hFF, "R4", {56'd0, sock_dir[7:0]}, 64'hFF);
        // R6 duplicate pins, highest bit wins
        do_define(4'd3, 32'h05050505, 32'h05050505);
        do_drive(4'd3, 4'd8, 8'h7F, 1'b1, "R6");
        chk(sock_lvl[4] == 1'b0, "R6", {63'd0, sock_lvl[4]}, 64'd0);
        do_drive(4'd3, 4'd2, 8'h02, 1'b1, "R6");
        chk(sock_lvl[4] == 1'b1, "R6", {63'd0, sock_lvl[4]}, 64'd1);
        // R7 R8 reads, zero count and busy poke
        do_read(4'd0, 4'd8, 5'd7, 40'h00000000A6, 1'b0, "R8");
        do_read(4'd0, 4'd0, 5'd9, 40'hFFFFFFFFFF, 1'b0, "R8");
        do_drive(4'd1, 4'd8, 8'h55, 1'b1, "R5");
        do_read(4'd1, 4'd5, 5'd31, 40'h5A5A5A5A5A, 1'b1, "R9");
        // R10 no-op
        issue(2'd3, 4'd1, 32'hFFFFFFFF, 32'hFFFFFFFF, 4'd8, 8'hFF, 1'b1, 5'd0);
        check_sock("R10");

        // Random mix
        for (int it = 0; it < 400; it++) begin
            int r = $urandom_range(0, 9);
            logic [3:0] b = 4'($urandom_range(0, 15));
            if (r == 0) chip_pins = 8'($urandom_range(0, 21) * 2);
            else if (r < 4) begin
                logic [31:0] lo, hi;
                for (int j = 0; j < 4; j++) begin
                    lo[j*8 +: 8] = 8'($urandom_range(0, 42));
                    hi[j*8 +: 8] = 8'($urandom_range(0, 42));
                end
                do_define(b, lo, hi);
            end else if (r < 7) do_drive(b, 4'($urandom_range(0, 15)), 8'($urandom), 1'($urandom), "R5");
            else do_read(b, 4'($urandom_range(0, 10)), 5'($urandom), {8'($urandom), 32'($urandom)}, (r == 9), "R8");
        end

        done = 1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule